// File: doc/BRIEF.md
# Issue-Stage Register Hazard Scoreboard

This block sits beside the issue slot of an in-order processor pipeline. It decides, in the same cycle, whether the instruction offered for issue may enter the pipeline. It keeps its own record of the instructions already in flight: one record per stage, holding the destination index and both source indices with their enable bits.

The candidate's source and destination indices are compared against every tracked record. The block raises a separate flag for each of four conflicts:

- **Read-after-write.** The candidate needs a value that an older instruction has not yet written back. This is the true data dependence.
- **Write-after-write.** The candidate writes the same register as an older instruction.
- **Write-after-read.** The candidate would overwrite a register that an older instruction has not yet read.
- **Divider conflict.** The candidate is a divide and the multi-cycle divider is still busy with an earlier one.

The write-after-write and write-after-read cases are name dependences. A stall output combines the four flags. While stall is high the issue slot is held, and a bubble enters the pipeline in place of the candidate. A flush discards every in-flight record at once.

Instructions advance one stage per clock, with no back-pressure from downstream. An accepted instruction enters stage 0 on the next edge. It is treated as written back once it leaves the last stage, `DEPTH` cycles later. Source operands are read while an instruction is in a stage numbered `READ_STAGE` or above. Records in stages below `READ_STAGE` therefore still have unread sources.

Top module: `hzd_scoreboard`

## Requirements
- R1: After reset, with `iss_valid` low, all outputs are 0. The tracker holds no records, so the first instruction offered sees no data hazard.
- R2: `haz_raw` is 1 when an enabled source index of the candidate equals the enabled destination index of any record in stages 0 to `DEPTH`-1.
- R3: `haz_waw` is 1 when the enabled destination index of the candidate equals the enabled destination index of any tracked record.
- R4: `haz_war` is 1 when the enabled destination index of the candidate equals an enabled source index of a record in a stage numbered below `READ_STAGE`. Records in later stages never cause it.
- R5: `haz_div` is 1 when `iss_is_div` and `div_busy` are both 1.
- R6: Register index 0 never takes part in a hazard. A comparison counts only when the enable bits on both sides are 1.
- R7: All flags are gated by `iss_valid` and by the absence of `flush`. `stall` is the OR of the four flags. `iss_accept` equals `iss_valid & ~stall & ~flush`.
- R8: An accepted instruction's record is in stage 0 in the next cycle. Each record moves one stage per cycle and is gone `DEPTH` cycles after it entered. A cycle without acceptance inserts an empty record.
- R9: While `flush` is 1, every flag, `stall` and `iss_accept` are 0. From the next cycle on, the tracker is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight records and the candidate |
| iss_valid | input | 1 | A candidate instruction is offered |
| iss_src_a_en | input | 1 | Candidate reads source A |
| iss_src_a | input | 5 | Source A register index |
| iss_src_b_en | input | 1 | Candidate reads source B |
| iss_src_b | input | 5 | Source B register index |
| iss_dst_en | input | 1 | Candidate writes a destination |
| iss_dst | input | 5 | Destination register index |
| iss_is_div | input | 1 | Candidate uses the divider |
| div_busy | input | 1 | Divider still working on an earlier divide |
| iss_accept | output | 1 | Candidate enters the pipeline at the next edge |
| stall | output | 1 | Hold the issue slot |
| haz_raw | output | 1 | Read-after-write conflict |
| haz_waw | output | 1 | Write-after-write conflict |
| haz_war | output | 1 | Write-after-read conflict |
| haz_div | output | 1 | Divider structural conflict |

## Verification
Every flag, `stall` and `iss_accept` are combinational in the current inputs and the tracked records. The bench therefore drives the candidate just after a falling edge and compares all six outputs about a nanosecond later, before the next rising edge.

The effect of an acceptance or a flush appears one rising edge later, in the record sequence. The reference model advances its own queue of stage records only after that edge. This places every comparison in the cycle when the tracker state matches the model state.

Directed sequences hold a stalled candidate until it is accepted. This confirms, for example, that a read-after-write stall lasts exactly until the producer leaves the last stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_IDX_W = 5;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    // One in-flight instruction as seen by the hazard logic.
    typedef struct packed {
        logic     dst_en;
        reg_idx_t dst;
        logic     a_en;
        reg_idx_t a;
        logic     b_en;
        reg_idx_t b;
    } instr_rec_t;

    localparam instr_rec_t REC_EMPTY = '0;

    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
    } data_haz_t;

    // Two register references collide only when both are enabled,
    // they name the same register, and that register is not index 0.
    function automatic logic idx_hit(logic en_x, reg_idx_t x,
                                     logic en_y, reg_idx_t y);
        return en_x & en_y & (x == y) & (x != '0);
    endfunction

endpackage

// File: rtl/hzd_track.sv
module hzd_track
    import hzd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    push,
    input  instr_rec_t              push_rec,
    output instr_rec_t [DEPTH-1:0]  stg_q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= REC_EMPTY;
        end else begin
            stg_q[0] <= push ? push_rec : REC_EMPTY;
            for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    // R8: an accepted record lands in stage 0
    a_r8_push_lands: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |=> (stg_q[0] == $past(push_rec)));

    // R9: a flush leaves the tracker empty
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (stg_q == '0));

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift_chk
            // R8: one stage per cycle
            a_r8_advance: assert property (@(posedge clk) disable iff (rst)
                !flush |=> (stg_q[g] == $past(stg_q[g-1])));
        end
    endgenerate

endmodule

// File: rtl/hzd_stage_cmp.sv
module hzd_stage_cmp
    import hzd_pkg::*;
#(
    parameter int STG_IDX    = 0,
    parameter int READ_STAGE = 1
) (
    input  instr_rec_t cand,
    input  instr_rec_t older,
    output data_haz_t  hit
);

    // Only records that have not reached the operand-read stage still
    // hold unread sources.
    localparam logic SRC_UNREAD = (STG_IDX < READ_STAGE);

    always_comb begin
        hit.raw = idx_hit(cand.a_en, cand.a, older.dst_en, older.dst)
                | idx_hit(cand.b_en, cand.b, older.dst_en, older.dst);
        hit.waw = idx_hit(cand.dst_en, cand.dst, older.dst_en, older.dst);
        hit.war = SRC_UNREAD
                & (idx_hit(cand.dst_en, cand.dst, older.a_en, older.a)
                 | idx_hit(cand.dst_en, cand.dst, older.b_en, older.b));
    end

endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
    import hzd_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int READ_STAGE = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 iss_valid,
    input  logic                 iss_src_a_en,
    input  logic [REG_IDX_W-1:0] iss_src_a,
    input  logic                 iss_src_b_en,
    input  logic [REG_IDX_W-1:0] iss_src_b,
    input  logic                 iss_dst_en,
    input  logic [REG_IDX_W-1:0] iss_dst,
    input  logic                 iss_is_div,
    input  logic                 div_busy,
    output logic                 iss_accept,
    output logic                 stall,
    output logic                 haz_raw,
    output logic                 haz_waw,
    output logic                 haz_war,
    output logic                 haz_div
);

    instr_rec_t               cand;
    instr_rec_t [DEPTH-1:0]   stg;
    data_haz_t  [DEPTH-1:0]   stg_hit;
    data_haz_t                any_hit;
    logic                     live;

    always_comb begin
        cand.dst_en = iss_dst_en;
        cand.dst    = iss_dst;
        cand.a_en   = iss_src_a_en;
        cand.a      = iss_src_a;
        cand.b_en   = iss_src_b_en;
        cand.b      = iss_src_b;
    end

    hzd_track #(.DEPTH(DEPTH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (iss_accept),
        .push_rec (cand),
        .stg_q    (stg)
    );

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
            hzd_stage_cmp #(.STG_IDX(s), .READ_STAGE(READ_STAGE)) u_cmp (
                .cand  (cand),
                .older (stg[s]),
                .hit   (stg_hit[s])
            );
        end
    endgenerate

    always_comb begin
        any_hit = '0;
        for (int s = 0; s < DEPTH; s++) begin
            any_hit.raw = any_hit.raw | stg_hit[s].raw;
            any_hit.waw = any_hit.waw | stg_hit[s].waw;
            any_hit.war = any_hit.war | stg_hit[s].war;
        end
    end

    assign live       = iss_valid & ~flush;
    assign haz_raw    = live & any_hit.raw;
    assign haz_waw    = live & any_hit.waw;
    assign haz_war    = live & any_hit.war;
    assign haz_div    = live & iss_is_div & div_busy;
    assign stall      = haz_raw | haz_waw | haz_war | haz_div;
    assign iss_accept = live & ~stall;

    // R7: a stalled candidate is never accepted
    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |-> !iss_accept);

    // R5: a divider conflict always holds the slot
    a_r5_div_stalls: assert property (@(posedge clk) disable iff (rst)
        haz_div |-> stall);

    // R9: after a flush no data hazard can be seen
    a_r9_clear_after_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> !(haz_raw || haz_waw || haz_war));

    // R9: nothing issues during a flush
    a_r9_no_issue_in_flush: assert property (@(posedge clk) disable iff (rst)
        flush |-> !(iss_accept || stall));

    // R6: destination index 0 takes part in no name dependence
    a_r6_zero_dst: assert property (@(posedge clk) disable iff (rst)
        (iss_dst == '0) |-> !(haz_waw || haz_war));

endmodule

// File: tb/hzd_scoreboard_tb.sv
module hzd_scoreboard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int READ_STAGE = 1;
    localparam int WDOG       = 20000;

    typedef struct {
        bit den; int d;
        bit aen; int a;
        bit ben; int b;
    } mrec_t;

    logic clk = 0, rst = 1, flush = 0, iss_valid = 0;
    logic iss_src_a_en = 0, iss_src_b_en = 0, iss_dst_en = 0;
    logic [4:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
    logic iss_is_div = 0, div_busy = 0;
    logic iss_accept, stall, haz_raw, haz_waw, haz_war, haz_div;

    int vectors = 0, miscompares = 0;
    bit last_acc;
    mrec_t pipe[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_scoreboard #(.DEPTH(DEPTH), .READ_STAGE(READ_STAGE)) u_dut (
        .clk(clk), .rst(rst), .flush(flush), .iss_valid(iss_valid),
        .iss_src_a_en(iss_src_a_en), .iss_src_a(iss_src_a),
        .iss_src_b_en(iss_src_b_en), .iss_src_b(iss_src_b),
        .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
        .iss_is_div(iss_is_div), .div_busy(div_busy),
        .iss_accept(iss_accept), .stall(stall), .haz_raw(haz_raw),
        .haz_waw(haz_waw), .haz_war(haz_war), .haz_div(haz_div));

    function automatic bit same(bit e1, int x, bit e2, int y);
        return e1 && e2 && x == y && x != 0;
    endfunction

    task automatic chk(string tag, logic act, bit exp, string note);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s (%s): actual %b expected %b at %0t", tag, note, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Compare the current cycle against the model, then advance one clock.
    task automatic step(string note);
        bit raw = 0, waw = 0, war = 0, dv, st, acc, live;
        mrec_t cur;
        #1;
        cur.den = iss_dst_en;   cur.d = int'(iss_dst);
        cur.aen = iss_src_a_en; cur.a = int'(iss_src_a);
        cur.ben = iss_src_b_en; cur.b = int'(iss_src_b);
        for (int s = 0; s < DEPTH; s++) begin
            if (same(cur.aen, cur.a, pipe[s].den, pipe[s].d) ||
                same(cur.ben, cur.b, pipe[s].den, pipe[s].d)) raw = 1;
            if (same(cur.den, cur.d, pipe[s].den, pipe[s].d)) waw = 1;
            if (s < READ_STAGE &&
                (same(cur.den, cur.d, pipe[s].aen, pipe[s].a) ||
                 same(cur.den, cur.d, pipe[s].ben, pipe[s].b))) war = 1;
        end
        live = iss_valid && !flush;
        raw &= live; waw &= live; war &= live;
        dv  = live && iss_is_div && div_busy;
        st  = raw || waw || war || dv;
        acc = live && !st;
        vectors++;
        chk("R2 haz_raw", haz_raw, raw, note);
        chk("R3 haz_waw", haz_waw, waw, note);
        chk("R4 haz_war", haz_war, war, note);
        chk("R5 haz_div", haz_div, dv, note);
        chk("R7 stall", stall, st, note);
        chk("R7 iss_accept", iss_accept, acc, note);
        last_acc = acc;
        @(posedge clk);
        #1;
        if (flush) begin
            foreach (pipe[i]) pipe[i] = '{0, 0, 0, 0, 0, 0};
        end else begin
            void'(pipe.pop_back());
            if (acc) pipe.push_front(cur);
            else     pipe.push_front('{0, 0, 0, 0, 0, 0});
        end
        @(negedge clk);
    endtask

    task automatic set_in(bit v, bit de, int d, bit ae, int a, bit be, int b, bit dv);
        iss_valid = v;
        iss_dst_en = de;   iss_dst = 5'(d);
        iss_src_a_en = ae; iss_src_a = 5'(a);
        iss_src_b_en = be; iss_src_b = 5'(b);
        iss_is_div = dv;
    endtask

    // Offer an instruction and hold it until the model says it is accepted.
    task automatic issue(string note, bit de, int d, bit ae, int a, bit be, int b, bit dv);
        set_in(1, de, d, ae, a, be, b, dv);
        for (int n = 0; n < 30; n++) begin
            step(note);
            if (last_acc) break;
        end
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step("idle");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) pipe.push_back('{0, 0, 0, 0, 0, 0});
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: quiet and empty after reset
        step("R1 reset idle");
        issue("R1 first issue free", 1, 5, 1, 1, 1, 2, 0);

        // R2 and R8: consumer of r5 stalls until the producer retires
        issue("R2 raw hold", 1, 6, 1, 5, 0, 0, 0);
        idle(DEPTH + 1);

        // R3: same destination twice
        issue("R3 first writer", 1, 7, 0, 0, 0, 0, 0);
        issue("R3 second writer", 1, 7, 1, 3, 0, 0, 0);
        idle(DEPTH + 1);

        // R4: older reads r9, younger writes r9 back to back
        issue("R4 older reader", 1, 10, 1, 9, 0, 0, 0);
        issue("R4 younger writer", 1, 9, 0, 0, 0, 0, 0);
        idle(DEPTH + 1);
        // R4: reader already two stages ahead, no WAR
        issue("R4 reader", 0, 0, 1, 11, 0, 0, 0);
        step("R4 gap");
        issue("R4 late writer", 1, 11, 0, 0, 0, 0, 0);
        idle(DEPTH + 1);

        // R5: divide while the divider is busy, then freed
        div_busy = 1;
        set_in(1, 1, 12, 1, 1, 0, 0, 1);
        step("R5 busy 1");
        step("R5 busy 2");
        div_busy = 0;
        issue("R5 divider free", 1, 12, 1, 1, 0, 0, 1);
        idle(DEPTH + 1);

        // R6: index 0 and disabled fields never collide
        issue("R6 write r0", 1, 0, 1, 0, 0, 0, 0);
        issue("R6 read r0", 1, 0, 1, 0, 1, 0, 0);
        issue("R6 disabled dst", 0, 13, 0, 0, 0, 0, 0);
        issue("R6 disabled src", 1, 14, 0, 13, 0, 13, 0);

        // R9: flush during a RAW stall clears the tracker
        issue("R9 producer", 1, 15, 0, 0, 0, 0, 0);
        set_in(1, 1, 16, 1, 15, 0, 0, 0);
        step("R9 stalled");
        flush = 1;
        step("R9 flush cycle");
        flush = 0;
        step("R9 after flush");
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        idle(DEPTH + 1);

        // R2 R3 R4 R5 R7 R8 R9: mixed random traffic with small indices
        for (int i = 0; i < 600; i++) begin
            set_in($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 7),
                   $urandom_range(0, 2) != 0, $urandom_range(0, 7),
                   $urandom_range(0, 2) != 0, $urandom_range(0, 7),
                   $urandom_range(0, 5) == 0);
            div_busy = $urandom_range(0, 2) == 0;
            flush = $urandom_range(0, 19) == 0;
            step("random");
        end
        flush = 0; div_busy = 0;
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        idle(DEPTH + 1);

        summary();
        $finish;
    end

endmodule